// File: doc/BRIEF.md
# Object and Playfield Priority Resolver with Collision Latches

This block sits at the end of a raster video pipeline. On every color clock it receives eight one-bit object coverage signals (four sprites and four narrow missile sprites) and four playfield-class coverage signals. It picks exactly one of nine color registers, or black, and drives that 8-bit color out one clock later. The choice follows a priority control register: four one-hot order bits rank the sprite pairs against the playfield pairs, a merge bit turns the four missiles into one combined sprite painted in the fourth playfield color, and a blend bit makes overlapping members of a sprite pair show the bitwise OR of their colors. Setting more than one order bit makes pixels where the conflicting classes overlap come out black.

In parallel the block keeps four sticky collision matrices (missile against playfield, sprite against playfield, missile against sprite, sprite against sprite). A host reads them one 4-bit row at a time through a combinational read port and wipes all of them with a single clear strobe. The host loads the color and priority registers through a simple write port.

Top module: `pix_prio_resolver`

## Requirements
- R1: After reset `pix_out` is 0x00, every collision row reads 0x00, and every color register and the priority register hold zero.
- R2: `pix_out` is registered: it shows the color resolved from the pixel inputs and the register contents of the previous clock; with no sprite, missile or playfield input active it shows the background color register.
- R3: Color registers keep bits 7:1 (hue in 7:4, luminance in 3:1); bit 0 of every color on `pix_out` is always 0, whatever was written.
- R4: Priority bits 3:0 set the order (groups: SA = sprites 0-1, SB = sprites 2-3, FA = playfields 0-1, FB = playfields 2-3; lower index wins inside a group, SA above SB, FA above FB): 0001 = SA,SB over FA,FB; 0010 = SA over FA,FB over SB; 0100 = FA,FB over SA,SB; 1000 = FA over SA,SB over FB; 0000 behaves as 0001.
- R5: With two or more order bits set, a pixel where a sprite group and a playfield group that those bits rank differently are both active outputs 0x00 (e.g. 1010 blacks SA over FA and SB over FB, but SA over FB shows the sprite).
- R6: Priority bit 4 set: each missile joins playfield 3 (its color and its rank) and no longer counts as its sprite; bit 4 clear: missile i shows and ranks as sprite i.
- R7: Priority bit 5 set: where both members of a sprite pair (0/1 or 2/3) are active, the output is the OR of their two color registers; bit 5 clear: the lower-index sprite shows.
- R8: Read address bits 3:2 select the matrix (0 missile-playfield, 1 sprite-playfield, 2 missile-sprite, 3 sprite-sprite) and bits 1:0 the row object; bit j of the row is set when the row object and object j of the column class are active in the same clock, stays set until cleared, and bits 7:4 read zero.
- R9: In the sprite-sprite matrix, a sprite's bit against itself always reads zero.
- R10: A clear strobe zeroes every collision bit in the next clock, and wins over a collision in the same clock.
- R11: Write addresses: 0-3 sprite colors, 4-7 playfield colors, 8 background color, 9 priority control; other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Color clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| clr_hit | input | 1 | Clear all collision bits |
| rd_addr | input | 4 | Collision row select |
| rd_data | output | 8 | Selected collision row, upper bits zero |
| spr_in | input | 4 | Sprite coverage for this pixel |
| msl_in | input | 4 | Missile coverage for this pixel |
| pf_in | input | 4 | Playfield class coverage for this pixel |
| pix_out | output | 8 | Resolved color, one clock late |

## Verification
The bench goes after the pixels where ordering decisions meet: a sprite pair over a playfield pair under each single order code, and mixed codes where a resolver that picked one bit's order instead of blacking would show a color, or one that blacked too eagerly would hide a sprite ranked consistently by both bits. It drives missiles with and without the merge bit, where a wrong resolver would paint a missile in its sprite's color or rank it with the sprites, and overlapping pairs with the blend bit, where a wrong one would show only one color. On the collision side it drives a lone sprite (a design that let it hit itself would set the diagonal) and a clear in the same clock as a hit (a design favouring the set would leave the bit standing).

// File: rtl/pxr_pkg.sv
package pxr_pkg;
   localparam int unsigned GRP_N   = 4;
   localparam int unsigned OBJ_N   = 4;
   localparam int unsigned ROW_N   = 16;
   localparam int unsigned GRP_SA  = 0;
   localparam int unsigned GRP_SB  = 1;
   localparam int unsigned GRP_FA  = 2;
   localparam int unsigned GRP_FB  = 3;
   localparam int unsigned WA_SPR0 = 0;
   localparam int unsigned WA_PF0  = 4;
   localparam int unsigned WA_BKG  = 8;
   localparam int unsigned WA_PRIO = 9;
   localparam int unsigned PR_W    = 6;
   localparam int unsigned PR_MERGE = 4;
   localparam int unsigned PR_BLEND = 5;
   typedef logic [PR_W-1:0] prio_t;
endpackage

// File: rtl/pxr_regs.sv
module pxr_regs
   import pxr_pkg::*;
#(
   parameter int unsigned CW = 8,
   parameter int unsigned AW = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_addr,
   input  logic [CW-1:0]                wr_data,
   output logic [OBJ_N-1:0][CW-1:0]     spr_col,
   output logic [OBJ_N-1:0][CW-1:0]     pf_col,
   output logic [CW-1:0]                bk_col,
   output prio_t                        prio
);
   logic [CW-1:1] bk_q;

   for (genvar i = 0; i < OBJ_N; i++) begin : g_col
      logic [CW-1:1] spr_q;
      logic [CW-1:1] pf_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            spr_q <= '0;
            pf_q  <= '0;
         end else if (wr_en) begin
            if (wr_addr == AW'(WA_SPR0 + i)) spr_q <= wr_data[CW-1:1];
            if (wr_addr == AW'(WA_PF0 + i))  pf_q  <= wr_data[CW-1:1];
         end
      end
      assign spr_col[i] = {spr_q, 1'b0};
      assign pf_col[i]  = {pf_q, 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bk_q <= '0;
         prio <= '0;
      end else if (wr_en) begin
         if (wr_addr == AW'(WA_BKG))  bk_q <= wr_data[CW-1:1];
         if (wr_addr == AW'(WA_PRIO)) prio <= wr_data[PR_W-1:0];
      end
   end
   assign bk_col = {bk_q, 1'b0};
endmodule

// File: rtl/pxr_resolve.sv
module pxr_resolve
   import pxr_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [OBJ_N-1:0][CW-1:0] spr_col,
   input  logic [OBJ_N-1:0][CW-1:0] pf_col,
   input  logic [CW-1:0]            bk_col,
   input  prio_t                    prio,
   input  logic [OBJ_N-1:0]         spr_in,
   input  logic [OBJ_N-1:0]         msl_in,
   input  logic [OBJ_N-1:0]         pf_in,
   output logic [CW-1:0]            pix_out
);
   logic [OBJ_N-1:0]            spr_eff;
   logic [OBJ_N-1:0]            pf_eff;
   logic [GRP_N-1:0]            act;
   logic [GRP_N-1:0][CW-1:0]    gcol;
   logic [1:0][1:0]             s_over;
   logic [1:0][1:0]             f_over;
   logic [GRP_N-1:0][GRP_N-1:0] beats;
   logic [GRP_N-1:0]            win;
   logic                        black;
   logic [CW-1:0]               nxt;
   logic [3:0]                  ord;

   assign ord = prio[3:0];

   // missiles either follow their own sprite or merge into playfield 3
   always_comb begin
      for (int i = 0; i < OBJ_N; i++)
         spr_eff[i] = spr_in[i] | (msl_in[i] & ~prio[PR_MERGE]);
      pf_eff = pf_in;
      pf_eff[OBJ_N-1] = pf_in[OBJ_N-1] | (prio[PR_MERGE] & (|msl_in));
   end

   for (genvar k = 0; k < 2; k++) begin : g_pair
      logic lo, hi;
      assign lo = spr_eff[2*k];
      assign hi = spr_eff[2*k+1];
      assign act[k]     = lo | hi;
      assign act[2 + k] = pf_eff[2*k] | pf_eff[2*k+1];
      always_comb begin
         if (lo && hi && prio[PR_BLEND]) gcol[k] = spr_col[2*k] | spr_col[2*k+1];
         else if (lo)                    gcol[k] = spr_col[2*k];
         else                            gcol[k] = spr_col[2*k+1];
         gcol[2 + k] = pf_eff[2*k] ? pf_col[2*k] : pf_col[2*k+1];
      end
   end

   // per order bit: which side of each sprite/playfield pair is in front
   always_comb begin
      s_over[0][0] = ord[0] | ord[1];
      s_over[0][1] = ord[0] | ord[1] | ord[3];
      s_over[1][0] = ord[0];
      s_over[1][1] = ord[0] | ord[3];
      f_over[0][0] = ord[2] | ord[3];
      f_over[0][1] = ord[2];
      f_over[1][0] = ord[1] | ord[2] | ord[3];
      f_over[1][1] = ord[1] | ord[2];
   end

   always_comb begin
      beats = '0;
      beats[GRP_SA][GRP_SB] = 1'b1;
      beats[GRP_FA][GRP_FB] = 1'b1;
      black = 1'b0;
      for (int p = 0; p < 2; p++) begin
         for (int f = 0; f < 2; f++) begin
            beats[p][2+f] = ~f_over[p][f];
            beats[2+f][p] = f_over[p][f] & ~s_over[p][f];
            black = black | (act[p] & act[2+f] & s_over[p][f] & f_over[p][f]);
         end
      end
   end

   always_comb begin
      for (int g = 0; g < GRP_N; g++) begin
         win[g] = act[g];
         for (int h = 0; h < GRP_N; h++)
            if (h != g) win[g] = win[g] & (~act[h] | beats[g][h]);
      end
   end

   always_comb begin
      nxt = bk_col;
      for (int g = GRP_N - 1; g >= 0; g--)
         if (win[g]) nxt = gcol[g];
      if (black) nxt = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pix_out <= '0;
      else        pix_out <= nxt;
   end
endmodule

// File: rtl/pxr_hits.sv
module pxr_hits
   import pxr_pkg::*;
#(
   parameter int unsigned CW = 8,
   parameter int unsigned AW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_hit,
   input  logic [OBJ_N-1:0]          spr_in,
   input  logic [OBJ_N-1:0]          msl_in,
   input  logic [OBJ_N-1:0]          pf_in,
   input  logic [AW-1:0]             rd_addr,
   output logic [CW-1:0]             rd_data,
   output logic [ROW_N-1:0][OBJ_N-1:0] hit_q
);
   logic [ROW_N-1:0][OBJ_N-1:0] hit_set;

   for (genvar i = 0; i < OBJ_N; i++) begin : g_row
      for (genvar j = 0; j < OBJ_N; j++) begin : g_col
         assign hit_set[0*OBJ_N + i][j] = msl_in[i] & pf_in[j];
         assign hit_set[1*OBJ_N + i][j] = spr_in[i] & pf_in[j];
         assign hit_set[2*OBJ_N + i][j] = msl_in[i] & spr_in[j];
         if (i == j) begin : g_diag
            assign hit_set[3*OBJ_N + i][j] = 1'b0;
         end else begin : g_off
            assign hit_set[3*OBJ_N + i][j] = spr_in[i] & spr_in[j];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_hit) hit_q <= '0;
      else                   hit_q <= hit_q | hit_set;
   end

   assign rd_data = {{(CW-OBJ_N){1'b0}}, hit_q[rd_addr]};
endmodule

// File: rtl/pix_prio_resolver.sv
module pix_prio_resolver
   import pxr_pkg::*;
#(
   parameter int unsigned CW    = 8,
   parameter int unsigned AW    = 4,
   parameter int unsigned NOBJ  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [CW-1:0]   wr_data,
   input  logic            clr_hit,
   input  logic [AW-1:0]   rd_addr,
   output logic [CW-1:0]   rd_data,
   input  logic [NOBJ-1:0] spr_in,
   input  logic [NOBJ-1:0] msl_in,
   input  logic [NOBJ-1:0] pf_in,
   output logic [CW-1:0]   pix_out
);
   localparam int unsigned ROWS = 4 * NOBJ;

   if (NOBJ != OBJ_N) begin : g_bad_nobj
      $error("pix_prio_resolver: NOBJ must be 4");
   end
   if (CW < PR_W) begin : g_bad_cw
      $error("pix_prio_resolver: CW must hold the priority field");
   end
   if ((1 << AW) < ROWS) begin : g_bad_aw
      $error("pix_prio_resolver: AW too narrow for the collision rows");
   end

   logic [OBJ_N-1:0][CW-1:0]     spr_col;
   logic [OBJ_N-1:0][CW-1:0]     pf_col;
   logic [CW-1:0]                bk_col;
   prio_t                        prio;
   logic [ROW_N-1:0][OBJ_N-1:0]  hit_q;

   pxr_regs #(.CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .spr_col(spr_col), .pf_col(pf_col),
      .bk_col(bk_col), .prio(prio)
   );

   pxr_resolve #(.CW(CW)) u_res (
      .clk(clk), .rst_n(rst_n), .spr_col(spr_col), .pf_col(pf_col),
      .bk_col(bk_col), .prio(prio), .spr_in(spr_in), .msl_in(msl_in),
      .pf_in(pf_in), .pix_out(pix_out)
   );

   pxr_hits #(.CW(CW), .AW(AW)) u_hits (
      .clk(clk), .rst_n(rst_n), .clr_hit(clr_hit), .spr_in(spr_in),
      .msl_in(msl_in), .pf_in(pf_in), .rd_addr(rd_addr),
      .rd_data(rd_data), .hit_q(hit_q)
   );
endmodule

// File: rtl/pxr_chk.sv
module pxr_chk
   import pxr_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        clr_hit,
   input logic [OBJ_N-1:0]            spr_in,
   input logic [OBJ_N-1:0]            msl_in,
   input logic [OBJ_N-1:0]            pf_in,
   input logic [CW-1:0]               pix_out,
   input logic [CW-1:0]               bk_col,
   input logic [ROW_N-1:0][OBJ_N-1:0] hit_q
);
   AST_IDLE_SHOWS_BKG: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_in == '0 && msl_in == '0 && pf_in == '0) |=> (pix_out == $past(bk_col))); // R2

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> (hit_q == '0)); // R10

   AST_HITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((hit_q & $past(hit_q)) == $past(hit_q))); // R8

   AST_PAIR_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_in[0] && spr_in[1] && !clr_hit) |=> hit_q[3*OBJ_N][1]); // R8

   AST_NO_SELF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q[12][0] | hit_q[13][1] | hit_q[14][2] | hit_q[15][3]) == 1'b0); // R9

   AST_RESET_BLACK: assert property (@(posedge clk)
      !rst_n |=> (pix_out == '0)); // R1
endmodule

bind pix_prio_resolver pxr_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_hit(clr_hit), .spr_in(spr_in),
   .msl_in(msl_in), .pf_in(pf_in), .pix_out(pix_out), .bk_col(bk_col),
   .hit_q(hit_q)
);

// File: tb/sim_pix_prio_resolver.sv
`timescale 1ns/1ps
module sim_pix_prio_resolver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       clr_hit = 1'b0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [3:0] spr_in = '0, msl_in = '0, pf_in = '0;
   logic [7:0] pix_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   pix_prio_resolver u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clr_hit(clr_hit), .rd_addr(rd_addr),
      .rd_data(rd_data), .spr_in(spr_in), .msl_in(msl_in), .pf_in(pf_in),
      .pix_out(pix_out)
   );

   // bench model state
   logic [7:0] m_spr [4];
   logic [7:0] m_pf  [4];
   logic [7:0] m_bk;
   logic [5:0] m_pr;
   logic [3:0] m_hit  [16];
   logic [3:0] m_pend [16];
   logic [7:0] exp_pix;
   string      exp_tag;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // rank of group g (0 SA,1 SB,2 FA,3 FB) under single order bit b; higher is in front
   function automatic int rank(input int b, input int g);
      int r0 [4] = '{3, 2, 1, 0};
      int r1 [4] = '{3, 0, 2, 1};
      int r2 [4] = '{1, 0, 3, 2};
      int r3 [4] = '{2, 1, 3, 0};
      case (b)
         0: return r0[g];
         1: return r1[g];
         2: return r2[g];
         default: return r3[g];
      endcase
   endfunction

   function automatic logic [7:0] model_pix(input logic [3:0] s, input logic [3:0] m, input logic [3:0] f);
      logic [3:0] se, fe;
      logic       a [4];
      logic [7:0] c [4];
      int         first, best, bestr;
      logic       blk;
      se = s | (m_pr[4] ? 4'h0 : m);
      fe = f;
      if (m_pr[4] && m != 0) fe[3] = 1'b1;
      a[0] = se[0] | se[1];  a[1] = se[2] | se[3];
      a[2] = fe[0] | fe[1];  a[3] = fe[2] | fe[3];
      c[0] = (se[0] && se[1] && m_pr[5]) ? (m_spr[0] | m_spr[1]) : (se[0] ? m_spr[0] : m_spr[1]);
      c[1] = (se[2] && se[3] && m_pr[5]) ? (m_spr[2] | m_spr[3]) : (se[2] ? m_spr[2] : m_spr[3]);
      c[2] = fe[0] ? m_pf[0] : m_pf[1];
      c[3] = fe[2] ? m_pf[2] : m_pf[3];
      if (!(a[0] || a[1] || a[2] || a[3])) return m_bk & 8'hFE;
      blk = 1'b0;
      for (int b1 = 0; b1 < 4; b1++)
         for (int b2 = 0; b2 < 4; b2++)
            if (m_pr[b1] && m_pr[b2])
               for (int p = 0; p < 2; p++)
                  for (int q = 2; q < 4; q++)
                     if (a[p] && a[q] &&
                         ((rank(b1, p) > rank(b1, q)) != (rank(b2, p) > rank(b2, q))))
                        blk = 1'b1;
      if (blk) return 8'h00;
      first = 0;
      for (int b = 3; b >= 0; b--) if (m_pr[b]) first = b;
      best = 0; bestr = -1;
      for (int g = 0; g < 4; g++)
         if (a[g] && rank(first, g) > bestr) begin best = g; bestr = rank(first, g); end
      return c[best] & 8'hFE;
   endfunction

   // one color clock: check last pixel, check a collision row, drive new stimulus
   task automatic step(input logic [3:0] s, input logic [3:0] m, input logic [3:0] f,
                       input logic we, input logic [3:0] wa, input logic [7:0] wd,
                       input logic clr, input string tag);
      @(negedge clk);
      cyc++;
      for (int r = 0; r < 16; r++) m_hit[r] = m_pend[r];
      check(exp_tag, pix_out, exp_pix);
      rd_addr = 4'($urandom_range(0, 15));
      #1;
      check("R8 row read", rd_data, {4'h0, m_hit[rd_addr]});
      spr_in = s; msl_in = m; pf_in = f;
      wr_en = we; wr_addr = wa; wr_data = wd; clr_hit = clr;
      exp_pix = model_pix(s, m, f);
      exp_tag = tag;
      if (we) begin
         if (wa < 4)       m_spr[wa] = wd;
         else if (wa < 8)  m_pf[wa - 4] = wd;
         else if (wa == 8) m_bk = wd;
         else if (wa == 9) m_pr = wd[5:0];
      end
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) begin
            if (m[i] && f[j]) m_pend[i][j] = 1'b1;
            if (s[i] && f[j]) m_pend[4+i][j] = 1'b1;
            if (m[i] && s[j]) m_pend[8+i][j] = 1'b1;
            if (s[i] && s[j] && i != j) m_pend[12+i][j] = 1'b1;
         end
      if (clr) for (int r = 0; r < 16; r++) m_pend[r] = 4'h0;
   endtask

   task automatic pix(input logic [3:0] s, input logic [3:0] m, input logic [3:0] f, input string tag);
      step(s, m, f, 1'b0, 4'h0, 8'h00, 1'b0, tag);
   endtask

   task automatic wr(input logic [3:0] wa, input logic [7:0] wd, input string tag);
      step(4'h0, 4'h0, 4'h0, 1'b1, wa, wd, 1'b0, tag);
   endtask

   // read a row between edges, against the committed model
   task automatic rd_row(input logic [3:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin m_spr[i] = 0; m_pf[i] = 0; end
      m_bk = 0; m_pr = 0;
      for (int r = 0; r < 16; r++) begin m_hit[r] = 0; m_pend[r] = 0; end
      exp_pix = 8'h00; exp_tag = "R1 reset";
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset pixel", pix_out, 8'h00);
      for (int a = 0; a < 16; a++) rd_row(4'(a), 8'h00, "R1 reset row");

      // register map and background
      wr(4'd0, 8'h13, "R1 idle");
      wr(4'd1, 8'h35, "R11 write");
      wr(4'd2, 8'h56, "R11 write");
      wr(4'd3, 8'h78, "R11 write");
      wr(4'd4, 8'h9B, "R11 write");
      wr(4'd5, 8'hAC, "R11 write");
      wr(4'd6, 8'hBD, "R11 write");
      wr(4'd7, 8'hCE, "R11 write");
      wr(4'd8, 8'hE1, "R11 write");
      wr(4'd12, 8'hFF, "R11 write");
      wr(4'd9, 8'h01, "R2 background");
      pix(4'h0, 4'h0, 4'h0, "R2 background");
      pix(4'h1, 4'h0, 4'h0, "R3 sprite0 lsb");
      pix(4'h5, 4'h0, 4'h1, "R4 code0001");
      wr(4'd9, 8'h04, "R4 idle");
      pix(4'h1, 4'h0, 4'h4, "R4 code0100");
      wr(4'd9, 8'h02, "R4 idle");
      pix(4'h4, 4'h0, 4'h1, "R4 code0010 pf over sb");
      pix(4'h1, 4'h0, 4'h4, "R4 code0010 sa over pf");
      wr(4'd9, 8'h08, "R4 idle");
      pix(4'h1, 4'h0, 4'h4, "R4 code1000 sa over fb");
      pix(4'h1, 4'h0, 4'h1, "R4 code1000 fa over sa");
      wr(4'd9, 8'h00, "R4 idle");
      pix(4'h8, 4'h0, 4'h1, "R4 code0000");
      wr(4'd9, 8'h0A, "R5 idle");
      pix(4'h1, 4'h0, 4'h1, "R5 black sa/fa");
      pix(4'h4, 4'h0, 4'h4, "R5 black sb/fb");
      pix(4'h1, 4'h0, 4'h4, "R5 consistent sa/fb");
      wr(4'd9, 8'h11, "R6 idle");
      pix(4'h0, 4'h2, 4'h0, "R6 merged missile");
      pix(4'h0, 4'h2, 4'h1, "R6 merged under pf0");
      wr(4'd9, 8'h01, "R6 idle");
      pix(4'h0, 4'h2, 4'h0, "R6 own missile");
      pix(4'h0, 4'h8, 4'h1, "R6 missile ranks as sprite");
      wr(4'd9, 8'h21, "R7 idle");
      pix(4'h3, 4'h0, 4'h0, "R7 blend 0/1");
      pix(4'hC, 4'h0, 4'h0, "R7 blend 2/3");
      wr(4'd9, 8'h01, "R7 idle");
      pix(4'h3, 4'h0, 4'h0, "R7 no blend");

      // collisions
      step(4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h0, 1'b1, "R10 clear");
      pix(4'h1, 4'h0, 4'h0, "R9 lone sprite");
      pix(4'h0, 4'h0, 4'h0, "R2 idle");
      rd_row(4'd12, 8'h00, "R9 self bit");
      pix(4'h3, 4'h1, 4'h4, "R8 pair hit");
      pix(4'h0, 4'h0, 4'h0, "R2 idle");
      rd_row(4'd12, 8'h02, "R8 sprite0 vs sprite1");
      rd_row(4'd13, 8'h01, "R8 sprite1 vs sprite0");
      rd_row(4'd0,  8'h04, "R8 missile0 vs pf2");
      rd_row(4'd8,  8'h03, "R8 missile0 vs sprites");
      pix(4'h0, 4'h0, 4'h0, "R2 idle");
      rd_row(4'd12, 8'h02, "R8 sticky");
      step(4'h3, 4'h0, 4'h0, 1'b0, 4'h0, 8'h0, 1'b1, "R10 clear with hit");
      pix(4'h0, 4'h0, 4'h0, "R2 idle");
      rd_row(4'd12, 8'h00, "R10 clear wins");

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] s, m, f;
         logic we, cl;
         logic [3:0] wa;
         string t;
         s = 4'($urandom & $urandom);
         m = 4'($urandom & $urandom & $urandom);
         f = 4'($urandom & $urandom);
         we = ($urandom_range(0, 9) == 0);
         wa = 4'($urandom_range(0, 11));
         cl = ($urandom_range(0, 40) == 0);
         t = ($countones(m_pr[3:0]) > 1) ? "R5 random" : "R4 random";
         step(s, m, f, we, wa, 8'($urandom), cl, t);
      end
      pix(4'h0, 4'h0, 4'h0, "R2 flush");
      pix(4'h0, 4'h0, 4'h0, "R2 flush");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule